// File: doc/BRIEF.md
# Supply-Low Interrupt Status Logic

This block turns two digital comparator decisions about the analog supply into a live supply-low status bit and a sticky interrupt flag. One comparator input reports that the supply is below the lower (assert) trip point. The other reports that it is above the upper (release) trip point. Both inputs are asynchronous and pass through a synchronizer. A two-state machine applies hysteresis between them, and every change of state, in either direction, sets the flag. Monitoring runs only while the mode input reports full-performance operation. In any other mode the status is frozen and no new flag events occur, but a flag that is already set is kept.

Beside it sits a second sticky flag that a one-cycle periodic timeout pulse sets. Each flag has its own enable and its own interrupt request. Software clears a flag by writing 1 to its bit of the clear word. A set event in the same cycle as a clear takes priority.

State machine: `ST_SUPPLY_OK` (status 0) and `ST_SUPPLY_LOW` (status 1). Transition `GO_LOW` (OK to LOW) happens when the synchronized below-input is 1 in full-performance mode. Transition `GO_OK` (LOW to OK) happens when the synchronized above-input is 1 in full-performance mode. In every other case the state holds (`HOLD`).

Top module: `lvmon_irq_top`

## Requirements
- R1: In full-performance mode with status 0, a 1 on `cmp_below` makes `lv_status` 1 at the third rising clock edge after the input change. There are two synchronizer flops, then the state register.
- R2: With status 1, `lv_status` stays 1 while the synchronized `cmp_above` is 0, whatever `cmp_below` does. It returns to 0, with the same three-edge latency, once `cmp_above` is 1 in full-performance mode.
- R3: Every change of `lv_status`, 0 to 1 or 1 to 0, sets `lv_flag` at the same clock edge as the status change.
- R4: `lv_irq` is 1 exactly when `lv_flag`, `lv_ie` and `full_perf` are all 1.
- R5: While `full_perf` is 0, `lv_status` holds its value and `lv_flag` is not set by comparator activity.
- R6: A dropping or rising `full_perf` does not change `lv_flag`. The flag stays at 1 until it is cleared or the block is reset.
- R7: A 1 on `tick_pulse` at a rising edge sets `pi_flag` at that edge. `pi_irq` is 1 exactly when `pi_flag` and `pi_ie` are both 1.
- R8: While `clr_wr` is 1, bit 0 of `clr_bits` clears `lv_flag` and bit 1 clears `pi_flag`. A 0 bit has no effect.
- R9: When a set event and a clear of the same flag fall on one edge, the flag ends at 1.
- R10: A synchronous active-high `rst` clears the status, both flags, both enables and the synchronizers.
- R11: While `en_wr` is 1, `lv_ie` loads `en_lv` and `pi_ie` loads `en_pi`. Otherwise both enables hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_below | input | 1 | Async: supply is below the assert trip point |
| cmp_above | input | 1 | Async: supply is above the release trip point |
| full_perf | input | 1 | 1 in full-performance mode |
| tick_pulse | input | 1 | One-cycle periodic timeout pulse |
| en_wr | input | 1 | Enable-register write strobe |
| en_lv | input | 1 | New value for the supply-low interrupt enable |
| en_pi | input | 1 | New value for the periodic interrupt enable |
| clr_wr | input | 1 | Flag-clear write strobe |
| clr_bits | input | 2 | Write-1-to-clear: bit 0 supply flag, bit 1 periodic flag |
| lv_status | output | 1 | Live supply-low status |
| lv_flag | output | 1 | Sticky supply-low interrupt flag |
| pi_flag | output | 1 | Sticky periodic interrupt flag |
| lv_ie | output | 1 | Supply-low interrupt enable |
| pi_ie | output | 1 | Periodic interrupt enable |
| lv_irq | output | 1 | Supply-low interrupt request |
| pi_irq | output | 1 | Periodic interrupt request |

## Verification
For each flag, a set event and a software clear can land on the same edge. The bench provokes this in two ways. For the supply flag, it drives a comparator change and raises the clear two edges later, so the clear meets the status change at the state register. For the periodic flag, it pulses `tick_pulse` in the same cycle as the clear. A behavioural model with delay queues predicts every output on every clock, and directed checks confirm the flag reads 1 afterwards. A mode drop in the middle of a comparator change is also run, to show that the status freezes and the flag is kept.

// File: rtl/lvmon_pkg.sv
package lvmon_pkg;
    typedef enum logic [0:0] {
        ST_SUPPLY_OK  = 1'b0,
        ST_SUPPLY_LOW = 1'b1
    } supply_state_t;

    localparam int unsigned FLAG_LV = 0;
    localparam int unsigned FLAG_PI = 1;
    localparam int unsigned NUM_FLAGS = 2;
endpackage

// File: rtl/lvmon_sync.sv
module lvmon_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d_async;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q_sync = stage[LAST];
endmodule

// File: rtl/lvmon_hyst_fsm.sv
module lvmon_hyst_fsm
    import lvmon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic below_i,
    input  logic above_i,
    output logic status_o,
    output logic change_o
);
    supply_state_t state_q, state_nx;

    // next-state: GO_LOW, GO_OK, HOLD
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_SUPPLY_OK:  if (active_i && below_i) state_nx = ST_SUPPLY_LOW;
            ST_SUPPLY_LOW: if (active_i && above_i) state_nx = ST_SUPPLY_OK;
            default:       state_nx = ST_SUPPLY_OK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SUPPLY_OK;
        else     state_q <= state_nx;
    end

    always_comb begin
        status_o = (state_q == ST_SUPPLY_LOW);
        change_o = (state_nx != state_q);
    end

    AST_HOLD_OFF_MODE: assert property (@(posedge clk) disable iff (rst)
        !active_i |=> $stable(status_o)); // R5
    AST_GO_LOW: assert property (@(posedge clk) disable iff (rst)
        (active_i && below_i && !status_o) |=> status_o); // R1
    AST_HYSTERESIS: assert property (@(posedge clk) disable iff (rst)
        (status_o && !above_i) |=> status_o); // R2
endmodule

// File: rtl/lvmon_flag.sv
module lvmon_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
        (set_i && clr_i) |=> flag_o); // R9
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o); // R6
endmodule

// File: rtl/lvmon_irq_top.sv
module lvmon_irq_top
    import lvmon_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmp_below,
    input  logic       cmp_above,
    input  logic       full_perf,
    input  logic       tick_pulse,
    input  logic       en_wr,
    input  logic       en_lv,
    input  logic       en_pi,
    input  logic       clr_wr,
    input  logic [1:0] clr_bits,
    output logic       lv_status,
    output logic       lv_flag,
    output logic       pi_flag,
    output logic       lv_ie,
    output logic       pi_ie,
    output logic       lv_irq,
    output logic       pi_irq
);
    localparam int unsigned CMP_W = 2;

    logic [CMP_W-1:0] cmp_sync;
    logic             status_change;
    logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;

    lvmon_sync #(.WIDTH(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({cmp_above, cmp_below}),
        .q_sync  (cmp_sync)
    );

    lvmon_hyst_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .active_i (full_perf),
        .below_i  (cmp_sync[0]),
        .above_i  (cmp_sync[1]),
        .status_o (lv_status),
        .change_o (status_change)
    );

    assign flag_set[FLAG_LV] = status_change;
    assign flag_set[FLAG_PI] = tick_pulse;

    generate
        for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
            assign flag_clr[g] = clr_wr && clr_bits[g];
            lvmon_flag u_flag (
                .clk    (clk),
                .rst    (rst),
                .set_i  (flag_set[g]),
                .clr_i  (flag_clr[g]),
                .flag_o (flag_q[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            lv_ie <= 1'b0;
            pi_ie <= 1'b0;
        end else if (en_wr) begin
            lv_ie <= en_lv;
            pi_ie <= en_pi;
        end
    end

    always_comb begin
        lv_flag = flag_q[FLAG_LV];
        pi_flag = flag_q[FLAG_PI];
        lv_irq  = lv_flag && lv_ie && full_perf;
        pi_irq  = pi_flag && pi_ie;
    end

    AST_CHANGE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        !$stable(lv_status) |-> lv_flag); // R3
    AST_TICK_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        tick_pulse |=> pi_flag); // R7
    AST_NO_IRQ_OFF_MODE: assert property (@(posedge clk) disable iff (rst)
        !full_perf |-> !lv_irq); // R4
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en_wr |=> ($stable(lv_ie) && $stable(pi_ie))); // R11
endmodule

// File: tb/tb_lvmon_irq_top.sv
module tb_lvmon_irq_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmp_below = 0, cmp_above = 0, full_perf = 0, tick_pulse = 0;
    logic en_wr = 0, en_lv = 0, en_pi = 0, clr_wr = 0;
    logic [1:0] clr_bits = 2'b00;
    logic lv_status, lv_flag, pi_flag, lv_ie, pi_ie, lv_irq, pi_irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    lvmon_irq_top dut (.*);

    // reference model
    bit q_below[$];
    bit q_above[$];
    bit m_status = 0, m_lvf = 0, m_pif = 0, m_lvie = 0, m_piie = 0;

    always @(posedge clk) begin
        bit dly_b, dly_a, nxt;
        cyc++;
        if (rst) begin
            q_below = '{0, 0};
            q_above = '{0, 0};
            m_status = 0; m_lvf = 0; m_pif = 0; m_lvie = 0; m_piie = 0;
        end else begin
            dly_b = q_below.pop_front();
            dly_a = q_above.pop_front();
            q_below.push_back(cmp_below);
            q_above.push_back(cmp_above);
            nxt = m_status;
            if (full_perf) begin
                if (!m_status && dly_b) nxt = 1;
                else if (m_status && dly_a) nxt = 0;
            end
            if (nxt != m_status) m_lvf = 1;
            else if (clr_wr && clr_bits[0]) m_lvf = 0;
            m_status = nxt;
            if (tick_pulse) m_pif = 1;
            else if (clr_wr && clr_bits[1]) m_pif = 0;
            if (en_wr) begin
                m_lvie = en_lv;
                m_piie = en_pi;
            end
        end
    end

    task automatic chk(input bit act, input bit exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%0b expected=%0b", req, $time, act, exp);
        end
    endtask

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (!rst) begin
            chk(lv_status, m_status, "R1 lv_status");
            chk(lv_flag, m_lvf, "R3 lv_flag");
            chk(pi_flag, m_pif, "R7 pi_flag");
            chk(lv_irq, m_lvf && m_lvie && full_perf, "R4 lv_irq");
            chk(pi_irq, m_pif && m_piie, "R7 pi_irq");
            chk(lv_ie, m_lvie, "R11 lv_ie");
            chk(pi_ie, m_piie, "R11 pi_ie");
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear(input logic [1:0] b);
        clr_wr = 1; clr_bits = b;
        step(1);
        clr_wr = 0; clr_bits = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(3);
        rst = 0;
        step(1);
        // R10: reset state
        chk(lv_status | lv_flag | pi_flag | lv_ie | pi_ie, 0, "R10 reset state");
        full_perf = 1;
        en_wr = 1; en_lv = 1; en_pi = 1; step(1); en_wr = 0; en_lv = 0;
        chk(lv_ie & pi_ie, 1, "R11 enables loaded");
        // R1: drop below
        cmp_below = 1; step(2);
        chk(lv_status, 0, "R1 not before third edge");
        step(1);
        chk(lv_status, 1, "R1 status set on third edge");
        chk(lv_flag, 1, "R3 flag on rise of status");
        chk(lv_irq, 1, "R4 irq asserted");
        clear(2'b10);
        chk(lv_flag, 1, "R8 wrong bit leaves flag");
        clear(2'b01);
        chk(lv_flag, 0, "R8 clear by bit0");
        // R2: hysteresis band
        cmp_below = 0; step(6);
        chk(lv_status, 1, "R2 holds in band");
        chk(lv_flag, 0, "R2 no flag in band");
        cmp_above = 1; step(3);
        chk(lv_status, 0, "R2 release above");
        chk(lv_flag, 1, "R3 flag on fall of status");
        clear(2'b01);
        cmp_above = 0; step(3);
        // R9: status change meets clear on same edge
        cmp_below = 1; step(2);
        clr_wr = 1; clr_bits = 2'b01; step(1);
        clr_wr = 0; clr_bits = 0;
        chk(lv_status, 1, "R9 status changed");
        chk(lv_flag, 1, "R9 set beats clear (lv)");
        clear(2'b01);
        // R5/R6: leave full-performance mode
        cmp_below = 0; step(2);
        full_perf = 0;
        chk(lv_irq, 0, "R4 no irq off mode");
        cmp_above = 1; step(6);
        chk(lv_status, 1, "R5 status frozen off mode");
        chk(lv_flag, 0, "R5 no flag off mode");
        full_perf = 1; step(1);
        chk(lv_status, 0, "R2 release after mode return");
        chk(lv_flag, 1, "R3 flag after mode return");
        full_perf = 0; step(3);
        chk(lv_flag, 1, "R6 flag kept across mode drop");
        chk(lv_irq, 0, "R4 irq masked off mode");
        full_perf = 1; step(1);
        chk(lv_irq, 1, "R4 irq back in mode");
        clear(2'b01);
        cmp_above = 0;
        // R7: periodic flag
        tick_pulse = 1; step(1); tick_pulse = 0;
        chk(pi_flag, 1, "R7 tick sets flag");
        chk(pi_irq, 1, "R7 pi irq");
        en_wr = 1; en_pi = 0; en_lv = 1; step(1); en_wr = 0;
        chk(pi_irq, 0, "R7 masked pi irq");
        tick_pulse = 1; clr_wr = 1; clr_bits = 2'b10; step(1);
        tick_pulse = 0; clr_wr = 0; clr_bits = 0;
        chk(pi_flag, 1, "R9 set beats clear (pi)");
        clr_bits = 2'b10; step(1); clr_bits = 0;
        chk(pi_flag, 1, "R8 no clear without strobe");
        clear(2'b10);
        chk(pi_flag, 0, "R8 clear by bit1");
        // R10: reset mid-run
        tick_pulse = 1; step(1); tick_pulse = 0;
        rst = 1; step(1); rst = 0; step(1);
        chk(pi_flag | lv_ie | lv_status, 0, "R10 reset clears");
        step(4);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule